// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block lets one CPU port perform lock-free read-modify-write sequences against a small internal memory. A linked load reads a word and arms a single reservation over the 64-byte aligned granule that holds it. A linked store only stages a data word and its target address inside the monitor. A later commit writes the staged word to memory, but only if the reservation has survived. The commit returns a status word through the same response path a load uses. Software reads that status and repeats the whole sequence after a failure.

The reservation is fragile on purpose. Several events break it: a write by another agent anywhere in the reserved granule, even a write of the same value; eviction or migration of the line that holds it; an interrupt being taken; a plain load; a plain store into the granule; and any commit. A new linked load replaces the old reservation, so only one reservation exists at a time.

Top module: `resv_monitor`

## Requirements
- R1: Synchronous active-low reset clears the reservation, the staging register and the response valid. A commit issued straight after reset reports failure.
- R2: A plain load and a linked load return the addressed memory word on `rsp_data`, with `rsp_valid` high, exactly one cycle after the request. Plain stores and linked stores give no response.
- R3: A linked load, then a linked store into the same granule, then a commit, writes the staged word to memory. The commit status on `rsp_data` is 0 for success and 1 for failure, and it appears one cycle after the commit request.
- R4: A linked store never writes memory by itself.
- R5: A commit fails and leaves memory unchanged when nothing was staged, when no reservation is held, or when the staged address lies outside the reserved granule.
- R6: A snoop write whose address shares bits above bit 5 with the reservation clears it, even if it writes back the value already stored. A snoop write to another granule leaves the reservation intact. Snoop writes update memory.
- R7: An eviction whose address falls in the reserved granule clears the reservation.
- R8: `irq_taken` clears the reservation in the cycle it is high. A commit in that same cycle fails.
- R9: A new linked load replaces any earlier reservation. A commit staged to the earlier granule then fails.
- R10: A plain load issued while a reservation is held clears it. So does a plain store into the reserved granule.
- R11: Every commit, successful or failed, clears both the reservation and the staging register, so a second commit right after a successful one fails.
- R12: A snoop write to the reserved granule in the same cycle as a commit makes the commit fail, and memory then holds the snoop data.

Operation codes on `req_op`: 0 none, 1 load, 2 store, 3 linked load, 4 linked store, 5 commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | CPU request strobe |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Data for store or linked store |
| rsp_valid | output | 1 | Response present, one cycle after a load, linked load or commit |
| rsp_data | output | DATA_W | Read data or commit status (0 ok, 1 fail) |
| snoop_wr_valid | input | 1 | Write by another agent |
| snoop_wr_addr | input | ADDR_W | Byte address of that write |
| snoop_wr_data | input | DATA_W | Data of that write |
| evict_valid | input | 1 | Line eviction or migration event |
| evict_addr | input | ADDR_W | Any byte address within the affected line |
| irq_taken | input | 1 | Interrupt entry or context switch |

## Verification
The case that needs care is a commit and a break event in the same cycle. This is a snoop write to the reserved granule, or an interrupt, arriving together with the commit request. The bench drives the commit and the competing input on the same falling edge. It then expects a failure status one cycle later, and a following load must show the snoop data, or the old value, instead of the staged word. The opposite case is also covered: a snoop to a different granule just before a commit must not prevent success.

// File: rtl/resv_pkg.sv
package resv_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_LOAD   = 3'd1,
        OP_STORE  = 3'd2,
        OP_LINK   = 3'd3,
        OP_STAGE  = 3'd4,
        OP_COMMIT = 3'd5
    } resv_op_e;

    localparam logic STATUS_OK   = 1'b0;
    localparam logic STATUS_FAIL = 1'b1;
endpackage

// File: rtl/resv_mem.sv
module resv_mem #(
    parameter int WADDR_W = 8,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rd_en,
    input  logic [WADDR_W-1:0] rd_idx,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               wa_en,
    input  logic [WADDR_W-1:0] wa_idx,
    input  logic [DATA_W-1:0]  wa_data,
    input  logic               wb_en,
    input  logic [WADDR_W-1:0] wb_idx,
    input  logic [DATA_W-1:0]  wb_data
);
    localparam int WORDS = 1 << WADDR_W;

    logic [DATA_W-1:0] store_q [WORDS];

    // Port B is applied last, so an external write wins a same-word clash.
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= store_q[rd_idx];
        if (wa_en) store_q[wa_idx] <= wa_data;
        if (wb_en) store_q[wb_idx] <= wb_data;
    end
endmodule

// File: rtl/resv_tracker.sv
module resv_tracker
    import resv_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int GRAN_LSB = 6,
    parameter int BYTE_LSB = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  resv_op_e                   req_op,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    input  logic                       snoop_valid,
    input  logic [ADDR_W-1:0]          snoop_addr,
    input  logic                       evict_valid,
    input  logic [ADDR_W-1:0]          evict_addr,
    input  logic                       irq_taken,
    output logic                       resv_valid,
    output logic                       stg_valid,
    output logic                       commit_ok,
    output logic [ADDR_W-BYTE_LSB-1:0] commit_idx,
    output logic [DATA_W-1:0]          commit_data
);
    localparam int GW = ADDR_W - GRAN_LSB;
    localparam int WW = ADDR_W - BYTE_LSB;

    typedef struct packed {
        logic              valid;
        logic [GW-1:0]     gran;
        logic              stg_valid;
        logic [WW-1:0]     stg_idx;
        logic [DATA_W-1:0] stg_data;
    } trk_t;

    trk_t trk_d, trk_q;

    logic          is_load, is_store, is_link, is_stage, is_commit;
    logic [GW-1:0] req_gran, snoop_gran, evict_gran, stg_gran, gran_eff;
    logic          snoop_hit_q, evict_hit_q, snoop_hit_eff, evict_hit_eff;
    logic          kill;
    logic          unused_lo;

    assign unused_lo = ^{req_addr[BYTE_LSB-1:0], snoop_addr[GRAN_LSB-1:0],
                         evict_addr[GRAN_LSB-1:0]};

    always_comb begin
        is_load   = req_valid && (req_op == OP_LOAD);
        is_store  = req_valid && (req_op == OP_STORE);
        is_link   = req_valid && (req_op == OP_LINK);
        is_stage  = req_valid && (req_op == OP_STAGE);
        is_commit = req_valid && (req_op == OP_COMMIT);

        req_gran   = req_addr[ADDR_W-1:GRAN_LSB];
        snoop_gran = snoop_addr[ADDR_W-1:GRAN_LSB];
        evict_gran = evict_addr[ADDR_W-1:GRAN_LSB];
        stg_gran   = trk_q.stg_idx[WW-1:GRAN_LSB-BYTE_LSB];
        gran_eff   = is_link ? req_gran : trk_q.gran;

        snoop_hit_q   = snoop_valid && (snoop_gran == trk_q.gran);
        evict_hit_q   = evict_valid && (evict_gran == trk_q.gran);
        snoop_hit_eff = snoop_valid && (snoop_gran == gran_eff);
        evict_hit_eff = evict_valid && (evict_gran == gran_eff);

        // The commit sees the reservation as it stood, minus any break this cycle.
        commit_ok = is_commit && trk_q.valid && trk_q.stg_valid &&
                    (stg_gran == trk_q.gran) &&
                    !irq_taken && !snoop_hit_q && !evict_hit_q;

        kill = irq_taken || is_load || is_commit || snoop_hit_eff ||
               evict_hit_eff || (is_store && (req_gran == gran_eff));

        trk_d       = trk_q;
        trk_d.gran  = gran_eff;
        trk_d.valid = (is_link || trk_q.valid) && !kill;

        if (is_link || is_commit) begin
            trk_d.stg_valid = 1'b0;
            trk_d.stg_idx   = '0;
            trk_d.stg_data  = '0;
        end else if (is_stage) begin
            trk_d.stg_valid = 1'b1;
            trk_d.stg_idx   = req_addr[ADDR_W-1:BYTE_LSB];
            trk_d.stg_data  = req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign resv_valid  = trk_q.valid;
    assign stg_valid   = trk_q.stg_valid;
    assign commit_idx  = trk_q.stg_idx;
    assign commit_data = trk_q.stg_data;
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int GRAN_LSB = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              snoop_wr_valid,
    input  logic [ADDR_W-1:0] snoop_wr_addr,
    input  logic [DATA_W-1:0] snoop_wr_data,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic              irq_taken
);
    localparam int BYTE_LSB = $clog2(DATA_W / 8);
    localparam int WW       = ADDR_W - BYTE_LSB;

    typedef struct packed {
        logic valid;
        logic is_status;
        logic status;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    resv_op_e          op;
    logic              resv_valid, stg_valid, commit_ok, cpu_we;
    logic [WW-1:0]     commit_idx, cpu_widx;
    logic [DATA_W-1:0] commit_data, cpu_wdata, mem_rd;
    logic              is_rd, is_store, is_commit;

    assign op = resv_op_e'(req_op);

    resv_tracker #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRAN_LSB(GRAN_LSB), .BYTE_LSB(BYTE_LSB)
    ) u_trk (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(op), .req_addr(req_addr), .req_wdata(req_wdata),
        .snoop_valid(snoop_wr_valid), .snoop_addr(snoop_wr_addr),
        .evict_valid(evict_valid), .evict_addr(evict_addr), .irq_taken(irq_taken),
        .resv_valid(resv_valid), .stg_valid(stg_valid), .commit_ok(commit_ok),
        .commit_idx(commit_idx), .commit_data(commit_data)
    );

    always_comb begin
        is_rd     = req_valid && ((op == OP_LOAD) || (op == OP_LINK));
        is_store  = req_valid && (op == OP_STORE);
        is_commit = req_valid && (op == OP_COMMIT);

        cpu_we    = is_store || commit_ok;
        cpu_widx  = is_store ? req_addr[ADDR_W-1:BYTE_LSB] : commit_idx;
        cpu_wdata = is_store ? req_wdata : commit_data;

        rsp_d.valid     = is_rd || is_commit;
        rsp_d.is_status = is_commit;
        rsp_d.status    = commit_ok ? STATUS_OK : STATUS_FAIL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    resv_mem #(.WADDR_W(WW), .DATA_W(DATA_W)) u_mem (
        .clk(clk),
        .rd_en(is_rd), .rd_idx(req_addr[ADDR_W-1:BYTE_LSB]), .rd_data(mem_rd),
        .wa_en(cpu_we), .wa_idx(cpu_widx), .wa_data(cpu_wdata),
        .wb_en(snoop_wr_valid), .wb_idx(snoop_wr_addr[ADDR_W-1:BYTE_LSB]),
        .wb_data(snoop_wr_data)
    );

    assign rsp_valid = rsp_q.valid;
    assign rsp_data  = rsp_q.is_status ? {{(DATA_W-1){1'b0}}, rsp_q.status} : mem_rd;
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk
    import resv_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic              irq_taken,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              resv_valid,
    input logic              stg_valid,
    input logic              cpu_we
);
    logic wants_rsp, is_commit, is_stage;
    assign is_commit = req_valid && (req_op == OP_COMMIT);
    assign is_stage  = req_valid && (req_op == OP_STAGE);
    assign wants_rsp = is_commit ||
                       (req_valid && ((req_op == OP_LOAD) || (req_op == OP_LINK)));

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!resv_valid && !stg_valid && !rsp_valid));

    a_r2_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
        wants_rsp |=> rsp_valid);

    a_r2_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !wants_rsp |=> !rsp_valid);

    a_r3_status_code: assert property (@(posedge clk) disable iff (!rst_n)
        is_commit |=> (rsp_data == '0 || rsp_data == DATA_W'(1)));

    a_r4_stage_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        is_stage |-> !cpu_we);

    a_r5_needs_resv: assert property (@(posedge clk) disable iff (!rst_n)
        (is_commit && !resv_valid) |=> (rsp_data == DATA_W'(1)));

    a_r8_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> !resv_valid);

    a_r11_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        is_commit |=> (!resv_valid && !stg_valid));
endmodule

bind resv_monitor resv_monitor_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .irq_taken(irq_taken), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .resv_valid(resv_valid), .stg_valid(stg_valid), .cpu_we(cpu_we)
);

// File: tb/sim_resv_monitor.sv
module sim_resv_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam logic [2:0] NONE = 3'd0, LOAD = 3'd1, STORE = 3'd2,
                           LINK = 3'd3, STAGE = 3'd4, COMMIT = 3'd5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          sn_v = 1'b0;
    logic [AW-1:0] sn_a = '0;
    logic [DW-1:0] sn_d = '0;
    logic          ev_v = 1'b0;
    logic [AW-1:0] ev_a = '0;
    logic          irq = 1'b0;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    logic          last_rv;
    logic [DW-1:0] last_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    resv_monitor u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .snoop_wr_valid(sn_v), .snoop_wr_addr(sn_a),
        .snoop_wr_data(sn_d), .evict_valid(ev_v), .evict_addr(ev_a),
        .irq_taken(irq)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, sample the registered response at the next one.
    task automatic step(input logic [2:0] o, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = (o != NONE);
        req_op    = o;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        last_rv   = rsp_valid;
        last_rd   = rsp_data;
        req_valid = 1'b0;
        req_op    = NONE;
        sn_v = 1'b0; ev_v = 1'b0; irq = 1'b0;
    endtask

    task automatic commit_expect(input string tag, input logic [DW-1:0] st);
        step(COMMIT, '0, '0);
        check({tag, " commit rsp_valid"}, {31'd0, last_rv}, 32'd1);
        check({tag, " commit status"}, last_rd, st);
    endtask

    task automatic load_expect(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] v);
        step(LOAD, a, '0);
        check({tag, " load data"}, last_rd, v);
    endtask

    task automatic t_r1_reset;
        check("R1 rsp_valid low in reset", {31'd0, rsp_valid}, 32'd0);
        commit_expect("R1 after reset", 32'd1);
    endtask

    task automatic t_r2_reads;
        step(STORE, 10'h040, 32'h11);
        check("R2 store gives no response", {31'd0, last_rv}, 32'd0);
        step(STORE, 10'h044, 32'h22);
        step(STORE, 10'h080, 32'h33);
        step(LOAD, 10'h040, '0);
        check("R2 load valid", {31'd0, last_rv}, 32'd1);
        check("R2 load data", last_rd, 32'h11);
        step(LINK, 10'h044, '0);
        check("R2 linked load data", last_rd, 32'h22);
    endtask

    task automatic t_r3_success;
        step(LINK, 10'h040, '0);
        step(STAGE, 10'h040, 32'hAA);
        check("R3 stage gives no response", {31'd0, last_rv}, 32'd0);
        commit_expect("R3 same word", 32'd0);
        load_expect("R3 memory updated", 10'h040, 32'hAA);
        step(LINK, 10'h040, '0);
        step(STAGE, 10'h07C, 32'h5C);
        commit_expect("R3 other word same granule", 32'd0);
        load_expect("R3 granule word written", 10'h07C, 32'h5C);
    endtask

    task automatic t_r4_r5_stage_only;
        step(STAGE, 10'h080, 32'h99);
        load_expect("R4 stage does not write", 10'h080, 32'h33);
        step(STAGE, 10'h080, 32'h99);
        commit_expect("R5 no reservation", 32'd1);
        load_expect("R5 memory kept", 10'h080, 32'h33);
        step(LINK, 10'h040, '0);
        commit_expect("R5 nothing staged", 32'd1);
        step(LINK, 10'h040, '0);
        step(STAGE, 10'h080, 32'h5);
        commit_expect("R5 staged outside granule", 32'd1);
        load_expect("R5 outside word kept", 10'h080, 32'h33);
    endtask

    task automatic t_r6_snoop;
        step(LINK, 10'h040, '0);
        sn_v = 1'b1; sn_a = 10'h040; sn_d = 32'hAA;
        step(NONE, '0, '0);
        step(STAGE, 10'h040, 32'h1);
        commit_expect("R6 same-value snoop breaks", 32'd1);
        load_expect("R6 memory holds snoop value", 10'h040, 32'hAA);
        step(LINK, 10'h040, '0);
        sn_v = 1'b1; sn_a = 10'h080; sn_d = 32'h44;
        step(NONE, '0, '0);
        step(STAGE, 10'h040, 32'h55);
        commit_expect("R6 snoop elsewhere keeps", 32'd0);
        load_expect("R6 snoop wrote memory", 10'h080, 32'h44);
        load_expect("R6 commit wrote memory", 10'h040, 32'h55);
    endtask

    task automatic t_r7_evict;
        step(LINK, 10'h040, '0);
        ev_v = 1'b1; ev_a = 10'h048;
        step(NONE, '0, '0);
        step(STAGE, 10'h040, 32'h77);
        commit_expect("R7 eviction breaks", 32'd1);
        load_expect("R7 memory kept", 10'h040, 32'h55);
    endtask

    task automatic t_r8_irq;
        step(LINK, 10'h040, '0);
        step(STAGE, 10'h040, 32'h78);
        irq = 1'b1;
        commit_expect("R8 irq with commit", 32'd1);
        load_expect("R8 memory kept", 10'h040, 32'h55);
        step(LINK, 10'h040, '0);
        irq = 1'b1;
        step(STAGE, 10'h040, 32'h79);
        commit_expect("R8 irq before commit", 32'd1);
    endtask

    task automatic t_r9_replace;
        step(LINK, 10'h040, '0);
        step(LINK, 10'h080, '0);
        step(STAGE, 10'h040, 32'h9);
        commit_expect("R9 older granule replaced", 32'd1);
        load_expect("R9 memory kept", 10'h040, 32'h55);
    endtask

    task automatic t_r10_plain;
        step(LINK, 10'h040, '0);
        step(STAGE, 10'h040, 32'hA1);
        step(LOAD, 10'h0C4, '0);
        commit_expect("R10 plain load breaks", 32'd1);
        step(LINK, 10'h040, '0);
        step(STORE, 10'h044, 32'h7);
        step(STAGE, 10'h040, 32'hA2);
        commit_expect("R10 plain store in granule breaks", 32'd1);
        load_expect("R10 memory kept", 10'h040, 32'h55);
    endtask

    task automatic t_r11_clear;
        step(LINK, 10'h040, '0);
        step(STAGE, 10'h040, 32'h66);
        commit_expect("R11 first commit", 32'd0);
        commit_expect("R11 second commit", 32'd1);
        load_expect("R11 memory", 10'h040, 32'h66);
    endtask

    task automatic t_r12_race;
        step(LINK, 10'h040, '0);
        step(STAGE, 10'h040, 32'h77);
        sn_v = 1'b1; sn_a = 10'h040; sn_d = 32'h88;
        commit_expect("R12 snoop with commit", 32'd1);
        load_expect("R12 snoop data wins", 10'h040, 32'h88);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_r1_reset_pre();
        rst_n = 1'b1;
        @(negedge clk);
        t_r1_reset();
        t_r2_reads();
        t_r3_success();
        t_r4_r5_stage_only();
        t_r6_snoop();
        t_r7_evict();
        t_r8_irq();
        t_r9_replace();
        t_r10_plain();
        t_r11_clear();
        t_r12_race();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    task automatic t_r1_reset_pre;
        check("R1 rsp_valid low during reset", {31'd0, rsp_valid}, 32'd0);
    endtask
endmodule